// File: doc/BRIEF.md
# Tag-Ordered Load/Store Queue with Speculative Loads

This block is the load/store queue of one data tile in a machine that runs code in atomic blocks and spreads memory traffic over several tiles by address. At block fetch the queue receives a 32-bit mask with one bit for each memory-operation tag present in the block. Tags are 5 bits wide, and tag order is program order. Memory operations then arrive one per cycle on a valid/ready stream. Each one is announced to peer tiles on a broadcast output, held in a slot indexed by its tag, and later offered to the cache on a second valid/ready stream.

A store, or a load that the wait predictor has flagged, is offered only once every lower tag in the mask has completed. A tag completes when it issues here, or when a peer tile reports it done. Other loads issue speculatively. Suppose a store arrives and a higher-tagged load to the same address has already issued. The queue then flags a squash carrying that load's tag, sets the load's wait flag and drops all pending state of the block. The block stays open until its operations are sent again. Once every masked tag has completed, the queue pulses commit, clears all wait flags and goes idle.

Back-pressure rules: `op_ready` is high exactly while a block is open and does not depend on `op_valid`. An operation transfers on a clock edge where `op_valid` and `op_ready` are both high. The issue stream transfers when `iss_valid` and `iss_ready` are both high. Until that transfer, the offered operation stays its slot's occupant, but a lower-tagged operation that becomes eligible takes its place in the offer.

Top module: `ldst_order_queue`

## Requirements
- R1: After reset `op_ready`, `iss_valid`, `commit` and `squash_valid` are all low.
- R2: `blk_start` loads `blk_mask` and raises `op_ready` only while no block is open. A `blk_start` during an open block is ignored. An arriving operation whose tag is not in the mask, or is already complete, is discarded. While no block is open, nothing is offered on the issue stream.
- R3: Every operation accepted on the arrival stream appears on `arr_bcast_valid`/`arr_bcast_tag` in the following cycle.
- R4: A store is offered only when every mask bit below its tag is complete. A tag completes through a local issue transfer or through a `peer_done_valid` report.
- R5: A load whose wait flag is clear is offered without waiting for lower tags. The one exception: while a lower-tagged store is still pending in this queue, the load is held back.
- R6: Among the eligible pending operations, the one with the lowest tag is offered.
- R7: An accepted store whose address equals that of an already issued load with a higher tag raises `squash_valid` in the next cycle, with `squash_tag` set to the lowest such load tag. In that cycle every pending slot and all completion state are cleared. A store to a different address causes no squash.
- R8: After a squash, the load named in it waits like a store (R4) for the rest of the block.
- R9: `commit` is a one-cycle pulse in the cycle after the last mask tag completes. `op_ready` then falls and all wait flags clear.
- R10: `commit` and `squash_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Start a block with `blk_mask` (only when idle) |
| blk_mask | input | 32 | Set of tags present in the block |
| op_valid | input | 1 | Arrival stream valid |
| op_ready | output | 1 | Arrival stream ready (block open) |
| op_tag | input | 5 | Tag of arriving operation |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_addr | input | 16 | Address of arriving operation |
| peer_done_valid | input | 1 | A peer tile reports a tag complete |
| peer_done_tag | input | 5 | Tag completed by a peer |
| arr_bcast_valid | output | 1 | Broadcast of an accepted arrival |
| arr_bcast_tag | output | 5 | Tag of the broadcast arrival |
| iss_valid | output | 1 | Issue stream valid |
| iss_ready | input | 1 | Issue stream ready from the cache |
| iss_tag | output | 5 | Tag of the offered operation |
| iss_store | output | 1 | Offered operation is a store |
| iss_addr | output | 16 | Address of the offered operation |
| commit | output | 1 | Block commit pulse |
| squash_valid | output | 1 | Ordering violation pulse |
| squash_tag | output | 5 | Tag of the violating load |

## Verification
A stale completion bit shows up at once at the issue port. A store is offered too early, or never, and the issue order departs from tag order within the cycle after the faulty update. A wrong issued-load record or wrong address storage shows up one cycle after the next store arrival, as a missing or spurious squash or a wrong squash tag. A predictor flag that is not set or not cleared shows up when the same load is sent again: it is offered immediately when it should wait, or the reverse. Commit errors show up as a missing, repeated or early pulse within a cycle of the last completion.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int TAG_W_DEF  = 5;
  localparam int ADDR_W_DEF = 16;
endpackage

// File: rtl/ldst_first_set.sv
module ldst_first_set #(
  parameter int N = 32,
  parameter int W = 5
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/ldst_tag_slots.sv
module ldst_tag_slots #(
  parameter int TAG_W  = ldst_pkg::TAG_W_DEF,
  parameter int ADDR_W = ldst_pkg::ADDR_W_DEF,
  localparam int NTAG  = 1 << TAG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       wr_store,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic                       iss_fire,
  input  logic [TAG_W-1:0]           iss_tag,
  input  logic [NTAG-1:0]            open_tags,
  input  logic [NTAG-1:0]            wait_flags,
  output logic [NTAG-1:0]            elig,
  output logic [NTAG-1:0]            slot_store,
  output logic [NTAG-1:0]            ld_issued,
  output logic [NTAG-1:0][ADDR_W-1:0] slot_addr
);
  logic [NTAG-1:0] slot_v;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      slot_v     <= '0;
      slot_store <= '0;
      ld_issued  <= '0;
    end else begin
      if (iss_fire) begin
        slot_v[iss_tag] <= 1'b0;
        if (!slot_store[iss_tag]) ld_issued[iss_tag] <= 1'b1;
      end
      if (wr_en) begin
        slot_v[wr_tag]     <= 1'b1;
        slot_store[wr_tag] <= wr_store;
        ld_issued[wr_tag]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_addr[wr_tag] <= wr_addr;
  end

  for (genvar g = 0; g < NTAG; g++) begin : g_elig
    localparam logic [NTAG-1:0] LOWER = (NTAG'(1) << g) - NTAG'(1);
    logic ordered;
    assign ordered = slot_store[g] | wait_flags[g];
    assign elig[g] = slot_v[g] &
                     (ordered ? ~|(open_tags & LOWER)
                              : ~|(slot_v & slot_store & LOWER));
  end

  AST_FIRE_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |-> slot_v[iss_tag]); // R6
endmodule

// File: rtl/ldst_squash_check.sv
module ldst_squash_check #(
  parameter int TAG_W  = ldst_pkg::TAG_W_DEF,
  parameter int ADDR_W = ldst_pkg::ADDR_W_DEF,
  localparam int NTAG  = 1 << TAG_W
) (
  input  logic                        chk,
  input  logic [TAG_W-1:0]            st_tag,
  input  logic [ADDR_W-1:0]           st_addr,
  input  logic [NTAG-1:0]             ld_issued,
  input  logic [NTAG-1:0][ADDR_W-1:0] slot_addr,
  output logic                        hit,
  output logic [TAG_W-1:0]            hit_tag
);
  logic [NTAG-1:0] viol;

  for (genvar g = 0; g < NTAG; g++) begin : g_cmp
    assign viol[g] = chk & ld_issued[g] & (TAG_W'(g) > st_tag) &
                     (slot_addr[g] == st_addr);
  end

  ldst_first_set #(.N(NTAG), .W(TAG_W)) u_pick (
    .req(viol), .found(hit), .idx(hit_tag)
  );
endmodule

// File: rtl/ldst_order_queue.sv
module ldst_order_queue #(
  parameter int TAG_W  = ldst_pkg::TAG_W_DEF,
  parameter int ADDR_W = ldst_pkg::ADDR_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blk_start,
  input  logic [(1<<TAG_W)-1:0]   blk_mask,
  input  logic                    op_valid,
  output logic                    op_ready,
  input  logic [TAG_W-1:0]        op_tag,
  input  logic                    op_is_store,
  input  logic [ADDR_W-1:0]       op_addr,
  input  logic                    peer_done_valid,
  input  logic [TAG_W-1:0]        peer_done_tag,
  output logic                    arr_bcast_valid,
  output logic [TAG_W-1:0]        arr_bcast_tag,
  output logic                    iss_valid,
  input  logic                    iss_ready,
  output logic [TAG_W-1:0]        iss_tag,
  output logic                    iss_store,
  output logic [ADDR_W-1:0]       iss_addr,
  output logic                    commit,
  output logic                    squash_valid,
  output logic [TAG_W-1:0]        squash_tag
);
  localparam int NTAG = 1 << TAG_W;

  logic            active;
  logic [NTAG-1:0] mask_q, done_q, wait_q;
  logic [NTAG-1:0] open_tags, elig, slot_store, ld_issued;
  logic [NTAG-1:0][ADDR_W-1:0] slot_addr;
  logic            accept, tag_live, wr_en, iss_fire, commit_now;
  logic            hit, st_chk;
  logic [TAG_W-1:0] hit_tag;
  logic [NTAG-1:0] fire_vec, peer_vec;

  assign open_tags  = mask_q & ~done_q;
  assign op_ready   = active;
  assign accept     = op_valid & active;
  assign tag_live   = mask_q[op_tag] & ~done_q[op_tag];
  assign st_chk     = accept & tag_live & op_is_store;
  assign wr_en      = accept & tag_live & ~hit;
  assign iss_fire   = iss_valid & iss_ready;
  assign commit_now = active & ~|open_tags;
  assign fire_vec   = iss_fire ? (NTAG'(1) << iss_tag) : '0;
  assign peer_vec   = peer_done_valid ? (NTAG'(1) << peer_done_tag) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      mask_q <= '0;
      done_q <= '0;
    end else if (!active) begin
      if (blk_start) begin
        active <= 1'b1;
        mask_q <= blk_mask;
        done_q <= '0;
      end
    end else if (commit_now) begin
      active <= 1'b0;
    end else if (hit) begin
      done_q <= '0;
    end else begin
      done_q <= done_q | fire_vec | peer_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q          <= '0;
      commit          <= 1'b0;
      squash_valid    <= 1'b0;
      squash_tag      <= '0;
      arr_bcast_valid <= 1'b0;
      arr_bcast_tag   <= '0;
    end else begin
      if (commit_now)  wait_q <= '0;
      else if (hit)    wait_q[hit_tag] <= 1'b1;
      commit          <= commit_now;
      squash_valid    <= hit;
      squash_tag      <= hit_tag;
      arr_bcast_valid <= accept;
      arr_bcast_tag   <= op_tag;
    end
  end

  ldst_tag_slots #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush(hit | commit_now),
    .wr_en(wr_en), .wr_tag(op_tag), .wr_store(op_is_store), .wr_addr(op_addr),
    .iss_fire(iss_fire), .iss_tag(iss_tag),
    .open_tags(open_tags), .wait_flags(wait_q),
    .elig(elig), .slot_store(slot_store), .ld_issued(ld_issued),
    .slot_addr(slot_addr)
  );

  ldst_squash_check #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_squash (
    .chk(st_chk), .st_tag(op_tag), .st_addr(op_addr),
    .ld_issued(ld_issued), .slot_addr(slot_addr),
    .hit(hit), .hit_tag(hit_tag)
  );

  ldst_first_set #(.N(NTAG), .W(TAG_W)) u_issue_pick (
    .req(elig), .found(iss_valid), .idx(iss_tag)
  );

  assign iss_store = slot_store[iss_tag];
  assign iss_addr  = slot_addr[iss_tag];

  AST_BCAST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (arr_bcast_valid && arr_bcast_tag == $past(op_tag))); // R3
  AST_STORE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_store) |-> ((open_tags & ((NTAG'(1) << iss_tag) - NTAG'(1))) == '0)); // R4
  AST_SQUASH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !iss_valid); // R7
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R9
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && squash_valid)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |-> !iss_valid); // R2
endmodule

// File: tb/ldst_order_queue_test.sv
module ldst_order_queue_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0;
  logic [31:0] blk_mask = '0;
  logic op_valid = 1'b0;
  logic [4:0] op_tag = '0;
  logic op_is_store = 1'b0;
  logic [15:0] op_addr = '0;
  logic peer_done_valid = 1'b0;
  logic [4:0] peer_done_tag = '0;
  logic iss_ready = 1'b1;
  logic op_ready, arr_bcast_valid, iss_valid, iss_store, commit, squash_valid;
  logic [4:0] arr_bcast_tag, iss_tag, squash_tag;
  logic [15:0] iss_addr;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ldst_order_queue uut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_mask(blk_mask),
    .op_valid(op_valid), .op_ready(op_ready), .op_tag(op_tag),
    .op_is_store(op_is_store), .op_addr(op_addr),
    .peer_done_valid(peer_done_valid), .peer_done_tag(peer_done_tag),
    .arr_bcast_valid(arr_bcast_valid), .arr_bcast_tag(arr_bcast_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .iss_store(iss_store), .iss_addr(iss_addr), .commit(commit),
    .squash_valid(squash_valid), .squash_tag(squash_tag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_block(input logic [31:0] m);
    @(negedge clk); blk_start = 1'b1; blk_mask = m;
    @(negedge clk); blk_start = 1'b0;
  endtask

  task automatic send(input logic [4:0] t, input logic st, input logic [15:0] a);
    @(negedge clk); op_valid = 1'b1; op_tag = t; op_is_store = st; op_addr = a;
    @(negedge clk); op_valid = 1'b0;
  endtask

  task automatic peer(input logic [4:0] t);
    @(negedge clk); peer_done_valid = 1'b1; peer_done_tag = t;
    @(negedge clk); peer_done_valid = 1'b0;
  endtask

  task automatic expect_commit(input string req);
    int seen = 0;
    int sq = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (commit) seen++;
      if (squash_valid) sq++;
    end
    check(req, seen, 1);
    check("R10 no squash around commit", sq, 0);
    check("R9 ready low after commit", op_ready, 0);
  endtask

  task automatic t_reset;
    check("R1 op_ready", op_ready, 0);
    check("R1 iss_valid", iss_valid, 0);
    check("R1 commit", commit, 0);
    check("R1 squash", squash_valid, 0);
  endtask

  task automatic t_store_order;
    start_block(32'h0000_000A);
    check("R2 ready after start", op_ready, 1);
    send(5'd3, 1'b1, 16'h0040);
    check("R3 bcast valid", arr_bcast_valid, 1);
    check("R3 bcast tag", arr_bcast_tag, 3);
    check("R4 store waits for tag1", iss_valid, 0);
    start_block(32'h0000_0008);
    repeat (2) @(negedge clk);
    check("R2 restart ignored", iss_valid, 0);
    peer(5'd1);
    check("R4 store offered", iss_valid, 1);
    check("R4 store tag", iss_tag, 3);
    check("R4 store kind", iss_store, 1);
    check("R4 store addr", iss_addr, 16'h0040);
    expect_commit("R9 commit after store");
  endtask

  task automatic t_squash;
    start_block(32'h0000_0005);
    send(5'd2, 1'b0, 16'h0010);
    check("R5 speculative load offered", iss_valid, 1);
    check("R5 load tag", iss_tag, 2);
    @(negedge clk);
    check("R5 load issued", iss_valid, 0);
    send(5'd0, 1'b1, 16'h0010);
    check("R7 squash flagged", squash_valid, 1);
    check("R7 squash tag", squash_tag, 2);
    check("R10 no commit with squash", commit, 0);
    check("R7 pending flushed", iss_valid, 0);
    @(negedge clk);
    check("R7 squash pulse", squash_valid, 0);
    send(5'd2, 1'b0, 16'h0010);
    check("R8 flagged load waits", iss_valid, 0);
    iss_ready = 1'b0;
    send(5'd0, 1'b1, 16'h0010);
    check("R7 no squash before load reissue", squash_valid, 0);
    check("R6 lowest tag first", iss_tag, 0);
    iss_ready = 1'b1;
    @(negedge clk);
    check("R8 load after store", iss_valid, 1);
    check("R8 load tag", iss_tag, 2);
    expect_commit("R9 commit after replay");
  endtask

  task automatic t_pred_cleared;
    start_block(32'h0000_0005);
    send(5'd2, 1'b0, 16'h0010);
    check("R9 wait flag cleared by commit", iss_valid, 1);
    check("R9 offered tag", iss_tag, 2);
    @(negedge clk);
    peer(5'd0);
    expect_commit("R9 commit via peer");
  endtask

  task automatic t_pick_order;
    logic [4:0] got [3];
    int n = 0;
    start_block(32'h0000_0052);
    iss_ready = 1'b0;
    send(5'd6, 1'b0, 16'h0030);
    check("R5 load offered early", iss_tag, 6);
    send(5'd1, 1'b0, 16'h0020);
    check("R6 lower tag displaces", iss_tag, 1);
    send(5'd4, 1'b1, 16'h0050);
    check("R7 no squash, load unissued", squash_valid, 0);
    iss_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (iss_valid && n < 3) begin got[n] = iss_tag; n++; end
      @(negedge clk);
    end
    check("R6 issue count", n, 3);
    check("R6 first", got[0], 1);
    check("R4 store second", got[1], 4);
    check("R5 load held behind store", got[2], 6);
    check("R9 committed", op_ready, 0);
  endtask

  task automatic t_diff_addr;
    start_block(32'h0000_0009);
    send(5'd3, 1'b0, 16'h0070);
    @(negedge clk);
    send(5'd0, 1'b1, 16'h0071);
    check("R7 different address no squash", squash_valid, 0);
    check("R4 store offered", iss_tag, 0);
    expect_commit("R9 commit diff addr");
  endtask

  task automatic t_drop;
    start_block(32'h0000_0001);
    iss_ready = 1'b0;
    send(5'd7, 1'b0, 16'h0001);
    check("R2 unmasked tag dropped", iss_valid, 0);
    iss_ready = 1'b1;
    peer(5'd0);
    expect_commit("R9 commit peer only");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_store_order();
    t_squash();
    t_pred_cleared();
    t_pick_order();
    t_diff_addr();
    t_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule